// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by reading two entries from page tables held in memory. The upper ten address bits select an entry in a page directory. The directory sits at the address given by a root register input. That entry locates a page table. The next ten bits select an entry in that page table, and that entry supplies the physical frame. The low twelve bits pass through unchanged, so pages are 4 kB.

A request enters on a valid/ready port. The walker then issues its two table reads one after the other on a simple memory read port. Each read uses a level request and a one-cycle data-valid strobe, and the latency is variable. The walker ends with a one-cycle response. The response carries either the physical address or a fault, and a fault states the level at which the walk stopped.

Every table entry is 32 bits wide. Bits 31:12 hold a 4 kB-aligned base (a table base or a frame number). Bit 0 is the present flag. Bits 11:1 carry no meaning for the walker. The address of an entry is the table base plus four times the index.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1 and both mem_req and rsp_valid are 0.
- R2: The cycle after a request is accepted, mem_req rises. The first read address is {root[31:12], 12'h000} + 4 * vaddr[31:22], and it is word aligned.
- R3: If the directory entry has bit 0 set, a second read follows at {dir_entry[31:12], 12'h000} + 4 * vaddr[21:12].
- R4: If both entries have bit 0 set, the response has rsp_fault = 0 and rsp_paddr = {table_entry[31:12], vaddr[11:0]}. Entry bits 11:1 have no effect on rsp_paddr.
- R5: A directory entry with bit 0 clear ends the walk with rsp_fault = 1 and rsp_fault_lvl = 0, and no second read is made.
- R6: A table entry with bit 0 clear ends the walk with rsp_fault = 1 and rsp_fault_lvl = 1.
- R7: Once mem_req is raised, it stays high with mem_addr unchanged until the cycle in which mem_rvalid is 1, whatever the latency (0 or more cycles).
- R8: req_ready is 1 only while no walk is in progress. A request presented while busy is not accepted and produces no response.
- R9: rsp_valid is high for exactly one cycle, in the cycle right after the final read's mem_rvalid, and never while mem_req is high.
- R10: The root and the logical address are captured when the request is accepted. Later changes to the root input do not affect a walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Logical address to translate |
| pt_root | input | 32 | Page directory base; bits 31:12 used |
| mem_req | output | 1 | Table read request, held until data returns |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read data valid strobe |
| mem_rdata | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address (0 on a fault) |
| rsp_fault | output | 1 | Walk ended on a non-present entry |
| rsp_fault_lvl | output | 1 | Failing level: 0 directory, 1 page table |

## Verification
The only timing fixed by the design is relative to the memory. The first read request is due in the cycle after the request is accepted. The response is due exactly one cycle after the mem_rvalid of the last read, and that read is the directory read for a level-0 fault and the table read otherwise. The memory model stamps each data strobe with the cycle count. The monitor samples at the falling edge, checks that the response arrives one cycle after that stamp, and compares the response with an expected item the driver queued at request time. While the memory model is waiting, it checks at every falling edge that the request is held with a stable address. Latencies of 0 to 5 cycles are used.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_DIR  = 2'd1,
        WS_PTE  = 2'd2,
        WS_DONE = 2'd3
    } walk_state_e;

    localparam logic LVL_DIR = 1'b0;
    localparam logic LVL_TBL = 1'b1;

endpackage

// File: rtl/pt_walker_addr.sv
module pt_walker_addr #(
    parameter int ADDR_W      = 32,
    parameter int OFF_W       = 12,
    parameter int IDX_W       = 10,
    parameter int ENTRY_SHIFT = 2,
    localparam int BASE_W     = ADDR_W - OFF_W
) (
    input  logic [BASE_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] table_start;
    logic [ADDR_W-1:0] idx_offset;

    assign table_start = {base, {OFF_W{1'b0}}};

    generate
        if (ENTRY_SHIFT == 0) begin : g_byte_entries
            assign idx_offset = ADDR_W'(idx);
        end else begin : g_wide_entries
            assign idx_offset = {{(ADDR_W-IDX_W-ENTRY_SHIFT){1'b0}}, idx, {ENTRY_SHIFT{1'b0}}};
        end
    endgenerate

    assign addr = table_start + idx_offset;
endmodule

// File: rtl/pt_walker_entry.sv
module pt_walker_entry #(
    parameter int ADDR_W      = 32,
    parameter int OFF_W       = 12,
    parameter int PRESENT_BIT = 0,
    localparam int BASE_W     = ADDR_W - OFF_W
) (
    input  logic [ADDR_W-1:0] entry,
    output logic [BASE_W-1:0] base,
    output logic              present
);
    logic unused_flags;

    assign base         = entry[ADDR_W-1:OFF_W];
    assign present      = entry[PRESENT_BIT];
    assign unused_flags = ^entry[OFF_W-1:0];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int OFF_W       = 12,
    parameter int IDX_W       = 10,
    parameter int ENTRY_SHIFT = 2,
    localparam int BASE_W     = ADDR_W - OFF_W,
    localparam int DIR_LO     = OFF_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [ADDR_W-1:0] pt_root,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_fault,
    output logic              rsp_fault_lvl
);
    typedef struct packed {
        walk_state_e       st;
        logic [ADDR_W-1:0] va;
        logic [BASE_W-1:0] base;
        logic [ADDR_W-1:0] pa;
        logic              flt;
        logic              lvl;
    } walk_t;

    walk_t             walk_d, walk_q;
    logic [IDX_W-1:0]  cur_idx;
    logic [BASE_W-1:0] ent_base;
    logic              ent_present;
    logic              unused_root;

    assign unused_root = ^pt_root[OFF_W-1:0];

    assign cur_idx = (walk_q.st == WS_DIR) ? walk_q.va[ADDR_W-1:DIR_LO]
                                           : walk_q.va[DIR_LO-1:OFF_W];

    pt_walker_addr #(
        .ADDR_W      (ADDR_W),
        .OFF_W       (OFF_W),
        .IDX_W       (IDX_W),
        .ENTRY_SHIFT (ENTRY_SHIFT)
    ) u_addr (
        .base (walk_q.base),
        .idx  (cur_idx),
        .addr (mem_addr)
    );

    pt_walker_entry #(
        .ADDR_W      (ADDR_W),
        .OFF_W       (OFF_W),
        .PRESENT_BIT (0)
    ) u_entry (
        .entry   (mem_rdata),
        .base    (ent_base),
        .present (ent_present)
    );

    always_comb begin
        walk_d = walk_q;
        unique case (walk_q.st)
            WS_IDLE: begin
                if (req_valid) begin
                    walk_d.st   = WS_DIR;
                    walk_d.va   = req_vaddr;
                    walk_d.base = pt_root[ADDR_W-1:OFF_W];
                    walk_d.pa   = '0;
                    walk_d.flt  = 1'b0;
                    walk_d.lvl  = LVL_DIR;
                end
            end
            WS_DIR: begin
                if (mem_rvalid) begin
                    if (ent_present) begin
                        walk_d.st   = WS_PTE;
                        walk_d.base = ent_base;
                    end else begin
                        walk_d.st  = WS_DONE;
                        walk_d.flt = 1'b1;
                        walk_d.lvl = LVL_DIR;
                    end
                end
            end
            WS_PTE: begin
                if (mem_rvalid) begin
                    walk_d.st = WS_DONE;
                    if (ent_present) begin
                        walk_d.pa = {ent_base, walk_q.va[OFF_W-1:0]};
                    end else begin
                        walk_d.flt = 1'b1;
                        walk_d.lvl = LVL_TBL;
                    end
                end
            end
            WS_DONE: begin
                walk_d.st = WS_IDLE;
            end
            default: begin
                walk_d.st = WS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q <= '{st: WS_IDLE, va: '0, base: '0, pa: '0, flt: 1'b0, lvl: 1'b0};
        end else begin
            walk_q <= walk_d;
        end
    end

    assign req_ready     = (walk_q.st == WS_IDLE);
    assign mem_req       = (walk_q.st == WS_DIR) || (walk_q.st == WS_PTE);
    assign rsp_valid     = (walk_q.st == WS_DONE);
    assign rsp_paddr     = walk_q.pa;
    assign rsp_fault     = walk_q.flt;
    assign rsp_fault_lvl = walk_q.lvl;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic              rsp_valid
);
    AST_ACCEPT_ISSUES_READ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> mem_req); // R2

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00); // R2

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr)); // R7

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready); // R8

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R9

    AST_RSP_NOT_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !mem_req && !req_ready); // R9
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .rsp_valid  (rsp_valid)
);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_vaddr;
    logic [31:0] pt_root;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic        rsp_fault_lvl;

    always #2.5 clk = ~clk;

    pt_walker u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .pt_root(pt_root), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl)
    );

    typedef struct {
        logic [31:0] a1;
        logic [31:0] a2;
        bit          two;
        logic [31:0] pa;
        bit          flt;
        bit          lvl;
    } exp_t;

    logic [31:0] mem [logic [31:0]];
    exp_t        exp_q[$];
    logic [31:0] obs_q[$];
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    int          last_rv = 0;
    int          fixed_lat = -1;
    int          lat_seed = 0;
    int          pushed = 0;
    int          seen = 0;
    bit          done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // memory model with variable latency; records addresses, checks R7 while waiting
    initial begin
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        forever begin
            @(negedge clk);
            if (mem_req) begin
                logic [31:0] a;
                int lat;
                a = mem_addr;
                obs_q.push_back(a);
                lat = (fixed_lat >= 0) ? fixed_lat : (lat_seed * 7 + 3) % 6;
                lat_seed++;
                for (int i = 0; i < lat; i++) begin
                    @(negedge clk);
                    chk(mem_req && mem_addr == a, "R7", "held address", mem_addr, a);
                end
                mem_rvalid = 1'b1;
                mem_rdata  = rd(a);
                last_rv    = cyc;
                @(negedge clk);
                mem_rvalid = 1'b0;
            end
        end
    end

    // monitor: pops expected items as responses appear
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_valid) begin
                seen++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected response", rsp_paddr, 32'h0);
                end else begin
                    exp_t e;
                    logic [31:0] o;
                    e = exp_q.pop_front();
                    chk(cyc == last_rv + 1, "R9", "response cycle", cyc, last_rv + 1);
                    o = (obs_q.size() > 0) ? obs_q.pop_front() : 32'hFFFF_FFFF;
                    chk(o == e.a1, "R2", "directory read address", o, e.a1);
                    if (e.two) begin
                        o = (obs_q.size() > 0) ? obs_q.pop_front() : 32'hFFFF_FFFF;
                        chk(o == e.a2, "R3", "table read address", o, e.a2);
                    end
                    chk(obs_q.size() == 0, "R5", "no extra reads", obs_q.size(), 0);
                    obs_q.delete();
                    chk(rsp_fault == e.flt, e.flt ? (e.lvl ? "R6" : "R5") : "R4",
                        "fault flag", rsp_fault, e.flt);
                    if (e.flt)
                        chk(rsp_fault_lvl == e.lvl, e.lvl ? "R6" : "R5", "fault level",
                            rsp_fault_lvl, e.lvl);
                    else
                        chk(rsp_paddr == e.pa, "R4", "physical address", rsp_paddr, e.pa);
                end
                @(negedge clk);
                chk(!rsp_valid, "R9", "single cycle strobe", rsp_valid, 0);
            end
        end
    end

    task automatic translate(input logic [31:0] va);
        exp_t e;
        logic [31:0] d, p;
        e.a1  = {pt_root[31:12], 12'h0} + {20'h0, va[31:22], 2'b00};
        d     = rd(e.a1);
        e.two = d[0];
        e.a2  = {d[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
        p     = rd(e.a2);
        e.pa  = '0;
        if (!d[0]) begin
            e.flt = 1; e.lvl = 0;
        end else if (!p[0]) begin
            e.flt = 1; e.lvl = 1;
        end else begin
            e.flt = 0; e.lvl = 0; e.pa = {p[31:12], va[11:0]};
        end
        exp_q.push_back(e);
        pushed++;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    function automatic logic [31:0] mkva(input int di, input int ti, input int off);
        return {di[9:0], ti[9:0], off[11:0]};
    endfunction

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_vaddr = '0;
        pt_root   = 32'h0010_0000;
        // directory entries
        mem[32'h0010_0000 + 4*1]     = 32'h0020_0F03;
        mem[32'h0010_0000 + 4*1023]  = 32'h0030_0001;
        mem[32'h0010_0000 + 4*2]     = 32'h0040_0FFE;
        // page table at 0x0020_0000
        mem[32'h0020_0000 + 4*0]     = 32'hABCD_EFFF;
        mem[32'h0020_0000 + 4*1023]  = 32'h1234_5001;
        mem[32'h0020_0000 + 4*5]     = 32'h5555_5000;
        for (int k = 10; k < 18; k++) mem[32'h0020_0000 + 4*k] = {20'h80000 + 20'(k), 12'h001};
        // page table at 0x0030_0000
        mem[32'h0030_0000 + 4*291]   = 32'hFFFF_F001;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
        chk(mem_req == 1'b0, "R1", "no read in reset", mem_req, 0);
        chk(rsp_valid == 1'b0, "R1", "no response in reset", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && !mem_req && !rsp_valid, "R1", "idle after reset",
            {req_ready, mem_req, rsp_valid}, 3'b100);

        // R2 R3 R4: successful walks with flag bits set in low entry bits
        translate(mkva(1, 0, 12'h7A5));
        translate(mkva(1, 1023, 12'hFFF));
        translate(mkva(1023, 291, 12'h000));
        // R5: directory not present (flag bits set but bit 0 clear)
        translate(mkva(2, 0, 12'h123));
        translate(mkva(0, 7, 12'h001));
        // R6: table entry not present
        translate(mkva(1, 5, 12'h456));
        translate(mkva(1023, 0, 12'h456));
        // mixed latencies
        for (int k = 10; k < 18; k++) translate(mkva(1, k, k * 37));
        // zero latency
        fixed_lat = 0;
        translate(mkva(1, 12, 12'hABC));
        translate(mkva(2, 12, 12'hABC));

        // R8: request held while busy is not accepted
        fixed_lat = 5;
        fork
            translate(mkva(1, 13, 12'h010));
            begin
                repeat (3) @(negedge clk);
                chk(req_ready == 1'b0, "R8", "not ready while walking", req_ready, 0);
                req_vaddr = mkva(1023, 291, 12'h020);
                req_valid = 1'b1;
                repeat (3) @(negedge clk);
                chk(req_ready == 1'b0, "R8", "still busy", req_ready, 0);
                req_valid = 1'b0;
            end
        join
        repeat (20) @(negedge clk);
        chk(seen == pushed, "R8", "response count", seen, pushed);

        // R10: root change during walk has no effect
        fixed_lat = 2;
        fork
            translate(mkva(1023, 291, 12'h3C3));
            begin
                repeat (3) @(negedge clk);
                pt_root = 32'hDEAD_0000;
            end
        join
        pt_root = 32'h0010_0000;
        chk(seen == pushed, "R10", "walk completed with captured root", seen, pushed);

        repeat (10) @(negedge clk);
        chk(seen == pushed, "R9", "no stray responses", seen, pushed);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule